// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a programmed mode word into the column address sequence of one SDRAM-style burst. Software or a controller writes the mode word with a load strobe. The block decodes four settings from it: the burst length (1, 2, 4, 8 or an endless full page), the ordering (sequential or interleaved), the read latency, and a write mode in which writes touch a single location while reads keep the programmed length. The decoded read latency is presented as a plain number for downstream pipeline logic. A mode word that carries a reserved code is refused: an error flag is raised and the earlier setting stays in force.

A start strobe with a starting column opens a burst. One cycle later the starting column appears with a valid flag. Each cycle that the advance enable is high moves the burst to its next beat. Within an aligned block of burst-length columns, sequential order counts the low address bits upward and wraps, and interleaved order XORs the beat number into them. A last-beat flag marks the final beat, and advancing past it closes the burst. A full-page burst runs modulo the column space until a stop is given. A new start during a burst abandons the old sequence.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid`, `last_beat` and `mode_err` are 0 and `rd_lat` is 3. The active setting is length 1, sequential order, and writes that burst like reads.
- R2: A start strobe sampled at one edge makes `col_valid` 1 and `col` equal to `start_col` after that edge.
- R3: With mode bit 3 = 0 and mode bits [2:0] = 000/001/010/011, the burst length is 1/2/4/8. Beat n is at (start & ~(L-1)) | ((start + n) & (L-1)), so the upper bits stay fixed.
- R4: With mode bit 3 = 1, beat n of a length-L burst is at start XOR n. Only the low log2(L) bits change.
- R5: Mode bits [2:0] = 111 with bit 3 = 0 select full page. Beat n is (start + n) mod 1024, `last_beat` never rises, and the burst ends only on stop or a new start.
- R6: `last_beat` is 1 exactly on the final beat of a finite burst. If advance is high on that beat, `col_valid` is 0 after the next edge.
- R7: While a burst is valid and advance, start and stop are low, `col` and `col_valid` hold.
- R8: A stop sampled without a start clears `col_valid` after that edge. If start and stop are sampled together, start wins.
- R9: A start during a valid burst drops the old sequence, and the new sequence begins at the next edge.
- R10: Mode bits [6:4] = 010 give `rd_lat` = 2 and 011 give `rd_lat` = 3. The new value shows after the load edge.
- R11: Any of the following on load sets `mode_err` to 1 and leaves every active setting unchanged: a length code of 100, 101 or 110; code 111 together with bit 3 = 1; or a latency code other than 010 or 011. A legal load clears `mode_err`.
- R12: With mode bit 9 = 1, a burst started with `start_wr` = 1 has length 1, while a read burst keeps the programmed length. With bit 9 = 0, writes burst like reads.
- R13: The length, order and write mode are captured at start. A mode load during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for `mode_word` |
| mode_word | input | 13 | Mode word: [2:0] length, [3] order, [6:4] latency, [9] write mode |
| start | input | 1 | Start a burst at `start_col` |
| start_col | input | 10 | Starting column |
| start_wr | input | 1 | The started burst is a write |
| stop | input | 1 | Terminate the current burst |
| advance | input | 1 | Move to the next beat this cycle |
| col | output | 10 | Current column address |
| col_valid | output | 1 | `col` holds a live beat |
| last_beat | output | 1 | Current beat is the final one |
| rd_lat | output | 2 | Decoded read latency in cycles |
| mode_err | output | 1 | Last mode load carried a reserved code |

## Verification
Several functions can fall in the same cycle: a start with a stop, a start with an advance on a live burst, and a mode load during a running burst. The bench raises start and stop together and expects the new column to be valid. It restarts a burst with advance still high and expects the new sequence from its first beat. It loads a shorter length mid-burst and expects the original eight beats to complete, with the last-beat flag on the eighth.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   // decoded, active burst setting
   typedef struct packed {
      logic [1:0] len_lg;     // log2 of finite burst length
      logic       full;       // endless full-page burst
      logic       ilv;        // interleaved order
      logic [1:0] rd_lat;     // read latency in cycles
      logic       wr_single;  // writes are single-beat
   } bcg_mode_t;

   localparam logic [2:0] BL_CODE_FULL = 3'b111;
   localparam logic [2:0] LAT_CODE_2   = 3'b010;
   localparam logic [2:0] LAT_CODE_3   = 3'b011;

   localparam bcg_mode_t BCG_MODE_RST = '{len_lg: 2'd0, full: 1'b0, ilv: 1'b0,
                                          rd_lat: 2'd3, wr_single: 1'b0};

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
   import bcg_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] word,
   output bcg_mode_t         mode,
   output logic [COL_W-1:0]  len_mask,
   output logic              err
);

   localparam int LG_MAX = 3;

   if (COL_W < LG_MAX) begin : g_bad_col
      $error("bcg_mode_reg: COL_W must cover an 8-beat burst");
   end
   if (MODE_W < 10) begin : g_bad_mode
      $error("bcg_mode_reg: MODE_W must reach the write-mode bit");
   end

   logic [2:0] bl_f, lat_f;
   logic       bt_f, wm_f;
   logic       bl_ok, lat_ok;
   bcg_mode_t  dec;

   assign bl_f  = word[2:0];
   assign bt_f  = word[3];
   assign lat_f = word[6:4];
   assign wm_f  = word[9];

   always_comb begin
      bl_ok  = (bl_f[2] == 1'b0) || ((bl_f == BL_CODE_FULL) && !bt_f);
      lat_ok = (lat_f == LAT_CODE_2) || (lat_f == LAT_CODE_3);
      dec.len_lg    = bl_f[1:0];
      dec.full      = bl_f[2];
      dec.ilv       = bt_f;
      dec.rd_lat    = lat_f[1:0];
      dec.wr_single = wm_f;
      if (dec.full) dec.len_lg = 2'd0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= BCG_MODE_RST;
         err  <= 1'b0;
      end else if (load) begin
         if (bl_ok && lat_ok) begin
            mode <= dec;
            err  <= 1'b0;
         end else begin
            err  <= 1'b1;
         end
      end
   end

   // mask of the bits that move inside the aligned block
   for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
      assign len_mask[gi] = mode.full || (gi < (1 << mode.len_lg) - 1 + 1 && gi < 32'(mode.len_lg));
   end

   p_lat_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.rd_lat == 2'd2) || (mode.rd_lat == 2'd3));

   p_err_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $stable(mode));

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
   import bcg_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bcg_mode_t        mode,
   input  logic [COL_W-1:0] len_mask,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             start_wr,
   input  logic             stop,
   input  logic             advance,
   output logic [COL_W-1:0] col,
   output logic             col_valid,
   output logic             last_beat
);

   logic [COL_W-1:0] base_q, beat_q, mask_q;
   logic             full_q, ilv_q, valid_q;
   logic             single;
   logic [COL_W-1:0] seq_col, ilv_col;

   assign single = mode.wr_single && start_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         beat_q  <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (start) begin
         base_q  <= start_col;
         beat_q  <= '0;
         mask_q  <= single ? '0 : len_mask;
         full_q  <= single ? 1'b0 : mode.full;
         ilv_q   <= mode.ilv;
         valid_q <= 1'b1;
      end else if (stop) begin
         valid_q <= 1'b0;
      end else if (valid_q && advance) begin
         if (last_beat) valid_q <= 1'b0;
         else           beat_q  <= beat_q + 1'b1;
      end
   end

   assign seq_col   = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
   assign ilv_col   = base_q ^ (beat_q & mask_q);
   assign col       = ilv_q ? ilv_col : seq_col;
   assign col_valid = valid_q;
   assign last_beat = valid_q && !full_q && (beat_q == mask_q);

   p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> col_valid && (col == $past(start_col)));

   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop && !start |=> !col_valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && !advance && !start && !stop |=> col_valid && $stable(col));

   p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat && advance && !start && !stop |=> !col_valid);

   p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_load,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic              start_wr,
   input  logic              stop,
   input  logic              advance,
   output logic [COL_W-1:0]  col,
   output logic              col_valid,
   output logic              last_beat,
   output logic [1:0]        rd_lat,
   output logic              mode_err
);

   bcg_mode_t        mode;
   logic [COL_W-1:0] len_mask;

   bcg_mode_reg #(.COL_W(COL_W), .MODE_W(MODE_W)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mode_load),
      .word     (mode_word),
      .mode     (mode),
      .len_mask (len_mask),
      .err      (mode_err)
   );

   bcg_seq #(.COL_W(COL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .len_mask  (len_mask),
      .start     (start),
      .start_col (start_col),
      .start_wr  (start_wr),
      .stop      (stop),
      .advance   (advance),
      .col       (col),
      .col_valid (col_valid),
      .last_beat (last_beat)
   );

   assign rd_lat = mode.rd_lat;

   p_full_no_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode.full && start && !start_wr |=> !last_beat);

endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_load = 1'b0;
   logic [12:0] mode_word = '0;
   logic        start = 1'b0;
   logic [9:0]  start_col = '0;
   logic        start_wr = 1'b0;
   logic        stop = 1'b0;
   logic        advance = 1'b0;
   logic [9:0]  col;
   logic        col_valid, last_beat, mode_err;
   logic [1:0]  rd_lat;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   burst_col_gen uut (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
      .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
      .advance(advance), .col(col), .col_valid(col_valid), .last_beat(last_beat),
      .rd_lat(rd_lat), .mode_err(mode_err)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [12:0] mw(input bit wm, input logic [2:0] lat,
                                      input bit bt, input logic [2:0] bl);
      return {3'b000, wm, 2'b00, lat, bt, bl};
   endfunction

   task automatic load(input logic [12:0] w);
      mode_word = w; mode_load = 1'b1;
      tick();
      mode_load = 1'b0;
   endtask

   // run one finite burst and compare every beat
   task automatic burst_chk(input logic [9:0] c0, input bit wr, input int len,
                            input bit ilv, input string rq);
      start = 1'b1; start_col = c0; start_wr = wr; advance = 1'b0;
      tick();
      start = 1'b0; advance = 1'b1;
      for (int n = 0; n < len; n++) begin
         int e;
         if (ilv) e = int'(c0) ^ n;
         else     e = (int'(c0) & ~(len - 1)) | ((int'(c0) + n) & (len - 1));
         check(rq, "valid", col_valid, 1);
         check(rq, "col", col, e);
         check(rq, "last", last_beat, (n == len - 1) ? 1 : 0);
         tick();
      end
      check(rq, "valid after last", col_valid, 0);
      advance = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "valid", col_valid, 0);
      check("R1", "last", last_beat, 0);
      check("R1", "err", mode_err, 0);
      check("R1", "rd_lat", rd_lat, 3);
      burst_chk(10'h155, 1'b0, 1, 1'b0, "R1");
      burst_chk(10'h155, 1'b1, 1, 1'b0, "R1");
   endtask

   task automatic t_seq();
      load(mw(0, 3'b010, 0, 3'b010));
      check("R10", "rd_lat 2", rd_lat, 2);
      burst_chk(10'h0E6, 1'b0, 4, 1'b0, "R3");
      load(mw(0, 3'b011, 0, 3'b001));
      check("R10", "rd_lat 3", rd_lat, 3);
      burst_chk(10'h3FF, 1'b0, 2, 1'b0, "R3");
      load(mw(0, 3'b011, 0, 3'b011));
      burst_chk(10'h2FD, 1'b0, 8, 1'b0, "R3");
   endtask

   task automatic t_ilv();
      load(mw(0, 3'b011, 1, 3'b011));
      burst_chk(10'h105, 1'b0, 8, 1'b1, "R4");
      load(mw(0, 3'b011, 1, 3'b010));
      burst_chk(10'h0E6, 1'b0, 4, 1'b1, "R4");
   endtask

   task automatic t_full();
      load(mw(0, 3'b011, 0, 3'b111));
      check("R5", "err", mode_err, 0);
      start = 1'b1; start_col = 10'h3FE; start_wr = 1'b0;
      tick();
      start = 1'b0; advance = 1'b1;
      for (int n = 0; n < 6; n++) begin
         check("R5", "col", col, (10'h3FE + n) % 1024);
         check("R5", "no last", last_beat, 0);
         tick();
      end
      stop = 1'b1;
      tick();
      stop = 1'b0; advance = 1'b0;
      check("R8", "stop clears", col_valid, 0);
   endtask

   task automatic t_hold_restart();
      load(mw(0, 3'b011, 0, 3'b011));
      start = 1'b1; start_col = 10'h010;
      tick();
      start = 1'b0;
      for (int n = 0; n < 3; n++) begin
         tick();
         check("R7", "hold col", col, 10'h010);
         check("R7", "hold valid", col_valid, 1);
      end
      advance = 1'b1;
      tick();
      check("R7", "advance resumes", col, 10'h011);
      load(mw(0, 3'b011, 0, 3'b010));   // R13: shrink length mid-burst
      for (int n = 2; n < 8; n++) begin
         check("R13", "col", col, 10'h010 + n);
         check("R13", "last", last_beat, (n == 7) ? 1 : 0);
         tick();
      end
      check("R13", "ends after 8", col_valid, 0);
      // R9: restart with advance held high
      start = 1'b1; start_col = 10'h020;
      tick();
      start = 1'b0;
      tick();
      check("R9", "old beat", col, 10'h021);
      start = 1'b1; start_col = 10'h043;
      tick();
      start = 1'b0;
      check("R9", "new beat0", col, 10'h043);
      tick();
      check("R9", "new beat1", col, 10'h040);
      // R8: start and stop together, start wins
      start = 1'b1; stop = 1'b1; start_col = 10'h100;
      tick();
      start = 1'b0; stop = 1'b0; advance = 1'b0;
      check("R8", "start wins valid", col_valid, 1);
      check("R8", "start wins col", col, 10'h100);
      stop = 1'b1;
      tick();
      stop = 1'b0;
      check("R8", "stop", col_valid, 0);
   endtask

   task automatic t_reserved();
      load(mw(0, 3'b010, 0, 3'b010));
      check("R11", "legal err", mode_err, 0);
      load(mw(0, 3'b011, 0, 3'b100));
      check("R11", "bl 100 err", mode_err, 1);
      check("R11", "lat kept", rd_lat, 2);
      burst_chk(10'h0E6, 1'b0, 4, 1'b0, "R11");
      load(mw(0, 3'b001, 0, 3'b000));
      check("R11", "lat 001 err", mode_err, 1);
      check("R11", "lat kept 2", rd_lat, 2);
      burst_chk(10'h0E6, 1'b0, 4, 1'b0, "R11");
      load(mw(0, 3'b011, 1, 3'b111));
      check("R11", "ilv full err", mode_err, 1);
      burst_chk(10'h0E6, 1'b0, 4, 1'b0, "R11");
      load(mw(0, 3'b011, 0, 3'b110));
      check("R11", "bl 110 err", mode_err, 1);
      load(mw(0, 3'b011, 0, 3'b001));
      check("R11", "legal clears", mode_err, 0);
      check("R10", "rd_lat 3 again", rd_lat, 3);
   endtask

   task automatic t_wmode();
      load(mw(1, 3'b011, 0, 3'b010));
      burst_chk(10'h0E6, 1'b1, 1, 1'b0, "R12");
      burst_chk(10'h0E6, 1'b0, 4, 1'b0, "R12");
      load(mw(1, 3'b011, 0, 3'b111));
      burst_chk(10'h200, 1'b1, 1, 1'b0, "R12");
      load(mw(0, 3'b011, 0, 3'b010));
      burst_chk(10'h0E6, 1'b1, 4, 1'b0, "R12");
   endtask

   bit done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      t_reset();
      t_seq();
      t_ilv();
      t_full();
      t_hold_restart();
      t_reserved();
      t_wmode();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule